// File: doc/BRIEF.md
# Polarity-Steered Line Output Latch

This block sits between the serial data path of a column driver and its per-channel converters. Gray codes of 6 bits come in one at a time and fill a line buffer slot by slot, starting at channel 1 and moving upward. A line strobe then controls the hand-over. Its rising edge rewinds the fill pointer so that the next line can start loading. Its falling edge copies the whole buffered line into an output latch. That latch keeps driving the converters until the next falling edge.

Each channel gets four outputs: its latched code, a ladder-select bit, a 2-bit gamma-segment index and a 4-bit step within that segment. The ladder-select bit chooses between the upper and the lower reference group. A polarity input decides whether the odd channels or the even channels get the upper group, and that input is captured together with the line. The number of channels is a parameter.

Top module: `pol_line_latch`

## Requirements
- R1: After reset every latched code, ladder-select bit, segment index and step output is zero. The outputs stay there until the first transfer.
- R2: Each write with `wr_valid` high stores `wr_code` in the next buffer slot. The first write after a pointer rewind goes to channel 1, which is bit field 0 of the flat vectors. Channel k uses bits [k*6 +: 6] of `ch_code`.
- R3: The cycle in which a rising edge of `line_strobe` is seen rewinds the fill pointer, so the next write lands in channel 1 again. A write presented in that same cycle is dropped.
- R4: A falling edge of `line_strobe` copies all buffered codes to `ch_code` on the clock edge where the low level is first sampled. In every other cycle `ch_code` holds its value.
- R5: Writes into the buffer, including writes made while the strobe is high, leave the outputs unchanged until the next falling edge.
- R6: Once all channels have been written, further writes are ignored until the next rising edge of the strobe.
- R7: At a transfer with `pol_sel` high, the odd channels (field 0, 2, ...) get `ch_upper` = 1 (upper ladder) and the even channels get 0. With `pol_sel` low the assignment is the reverse.
- R8: `pol_sel` is sampled only at the falling strobe edge. Changes to it between transfers have no effect on `ch_upper`.
- R9: For every channel, `ch_seg` is bits 5:4 of its latched code and `ch_step` is bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe for one channel code |
| wr_code | input | 6 | Gray code to store in the next slot |
| line_strobe | input | 1 | Line strobe: rise rewinds the pointer, fall transfers the line |
| pol_sel | input | 1 | Polarity: high puts odd channels on the upper ladder |
| ch_code | output | N_CH*6 | Latched code per channel |
| ch_upper | output | N_CH | Ladder select per channel, 1 selects the upper group |
| ch_seg | output | N_CH*2 | Gamma segment index per channel |
| ch_step | output | N_CH*4 | Step within the segment per channel |

## Verification
The assertions assume that `line_strobe` and `pol_sel` are synchronous to `clk`. They also assume the strobe is held at each level for at least one clock, which lets a single registered copy of the strobe find both edges. The bench changes every input only at falling clock edges. It raises the strobe in a cycle with no write and drives `pol_sel` to its new value no later than the cycle that lowers the strobe. This keeps the stimulus inside the setup and hold window the latch relies on.

// File: rtl/lol_pkg.sv
package lol_pkg;
    localparam int CODE_W = 6;
    localparam int SEG_W  = 2;
    localparam int STEP_W = CODE_W - SEG_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        LADDER_LOW  = 1'b0,
        LADDER_HIGH = 1'b1
    } ladder_e;
endpackage

// File: rtl/lol_strobe_edge.sv
module lol_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic lvl;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = strobe;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = strobe & ~st_q.lvl;
    assign fall = ~strobe & st_q.lvl;
endmodule

// File: rtl/lol_line_buffer.sv
module lol_line_buffer
    import lol_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  wr_valid,
    input  code_t                 wr_code,
    output code_t [N_CH-1:0]      line
);
    localparam int PTR_W = $clog2(N_CH + 1);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        code_t [N_CH-1:0]  slots;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else if (wr_valid && (st_q.ptr < PTR_W'(N_CH))) begin
            for (int i = 0; i < N_CH; i++) begin
                if (st_q.ptr == PTR_W'(i)) st_d.slots[i] = wr_code;
            end
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign line = st_q.slots;
endmodule

// File: rtl/lol_out_latch.sv
module lol_out_latch
    import lol_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  xfer,
    input  logic                  pol_sel,
    input  code_t [N_CH-1:0]      line,
    output code_t [N_CH-1:0]      codes,
    output logic  [N_CH-1:0]      upper
);
    typedef struct packed {
        code_t [N_CH-1:0]  codes;
        ladder_e [N_CH-1:0] ladder;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xfer) begin
            st_d.codes = line;
            for (int i = 0; i < N_CH; i++) begin
                // field i is channel i+1: even fields are odd channels
                if ((i % 2) == 0)
                    st_d.ladder[i] = pol_sel ? LADDER_HIGH : LADDER_LOW;
                else
                    st_d.ladder[i] = pol_sel ? LADDER_LOW : LADDER_HIGH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.codes <= '0;
            for (int i = 0; i < N_CH; i++) st_q.ladder[i] <= LADDER_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign codes = st_q.codes;
    always_comb begin
        for (int i = 0; i < N_CH; i++) upper[i] = (st_q.ladder[i] == LADDER_HIGH);
    end
endmodule

// File: rtl/lol_chan_split.sv
module lol_chan_split
    import lol_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  code_t [N_CH-1:0]               codes,
    output logic  [N_CH-1:0][SEG_W-1:0]    seg,
    output logic  [N_CH-1:0][STEP_W-1:0]   step
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign seg[g]  = codes[g][CODE_W-1 -: SEG_W];
        assign step[g] = codes[g][STEP_W-1:0];
    end
endmodule

// File: rtl/pol_line_latch.sv
module pol_line_latch
    import lol_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    input  logic [CODE_W-1:0]          wr_code,
    input  logic                       line_strobe,
    input  logic                       pol_sel,
    output logic [N_CH*CODE_W-1:0]     ch_code,
    output logic [N_CH-1:0]            ch_upper,
    output logic [N_CH*SEG_W-1:0]      ch_seg,
    output logic [N_CH*STEP_W-1:0]     ch_step
);
    logic                          strb_rise;
    logic                          strb_fall;
    code_t [N_CH-1:0]              buf_line;
    code_t [N_CH-1:0]              lat_codes;
    logic  [N_CH-1:0][SEG_W-1:0]   seg_v;
    logic  [N_CH-1:0][STEP_W-1:0]  step_v;

    lol_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (line_strobe),
        .rise   (strb_rise),
        .fall   (strb_fall)
    );

    lol_line_buffer #(.N_CH(N_CH)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clr      (strb_rise),
        .wr_valid (wr_valid),
        .wr_code  (wr_code),
        .line     (buf_line)
    );

    lol_out_latch #(.N_CH(N_CH)) u_lat (
        .clk     (clk),
        .rst     (rst),
        .xfer    (strb_fall),
        .pol_sel (pol_sel),
        .line    (buf_line),
        .codes   (lat_codes),
        .upper   (ch_upper)
    );

    lol_chan_split #(.N_CH(N_CH)) u_split (
        .codes (lat_codes),
        .seg   (seg_v),
        .step  (step_v)
    );

    assign ch_code = lat_codes;
    assign ch_seg  = seg_v;
    assign ch_step = step_v;
endmodule

// File: rtl/pol_line_latch_chk.sv
module pol_line_latch_chk #(
    parameter int N_CH = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  line_strobe,
    input logic                  pol_sel,
    input logic [N_CH*6-1:0]     ch_code,
    input logic [N_CH-1:0]       ch_upper
);
    logic strb_p;
    logic rst_seen;

    always_ff @(posedge clk) begin
        if (rst) strb_p <= 1'b0;
        else     strb_p <= line_strobe;
    end

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (!rst && rst_seen)
            reset_zero_chk: assert (ch_code == '0 && ch_upper == '0)
                else $error("outputs not cleared by reset");
    end

    // R4
    xfer_only_chk: assert property (@(posedge clk) disable iff (rst)
        !(strb_p && !line_strobe) |=> $stable(ch_code));

    // R7
    pol_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (strb_p && !line_strobe) |=> (ch_upper[0] == $past(pol_sel)));

    // R8
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(strb_p && !line_strobe) |=> $stable(ch_upper));
endmodule

bind pol_line_latch pol_line_latch_chk #(.N_CH(N_CH)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .line_strobe (line_strobe),
    .pol_sel     (pol_sel),
    .ch_code     (ch_code),
    .ch_upper    (ch_upper)
);

// File: tb/test_pol_line_latch.sv
module test_pol_line_latch;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_valid = 1'b0;
    logic [5:0]     wr_code = '0;
    logic           line_strobe = 1'b0;
    logic           pol_sel = 1'b0;
    logic [N*6-1:0] ch_code;
    logic [N-1:0]   ch_upper;
    logic [N*2-1:0] ch_seg;
    logic [N*4-1:0] ch_step;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [5:0] mdl_buf [N];
    logic [5:0] mdl_out [N];
    logic       mdl_up  [N];
    int         mdl_ptr = 0;

    always #5 clk = ~clk;

    pol_line_latch #(.N_CH(N)) i_pol_line_latch (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_code(wr_code),
        .line_strobe(line_strobe), .pol_sel(pol_sel),
        .ch_code(ch_code), .ch_upper(ch_upper), .ch_seg(ch_seg), .ch_step(ch_step)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req_code, string req_up);
        logic [N*6-1:0] e_code;
        logic [N-1:0]   e_up;
        logic [N*2-1:0] e_seg;
        logic [N*4-1:0] e_step;
        for (int i = 0; i < N; i++) begin
            e_code[i*6 +: 6] = mdl_out[i];
            e_up[i]          = mdl_up[i];
            e_seg[i*2 +: 2]  = mdl_out[i][5:4];
            e_step[i*4 +: 4] = mdl_out[i][3:0];
        end
        chk(req_code, 64'(ch_code), 64'(e_code));
        chk(req_up, 64'(ch_upper), 64'(e_up));
        chk("R9 seg", 64'(ch_seg), 64'(e_seg));
        chk("R9 step", 64'(ch_step), 64'(e_step));
    endtask

    // all drive tasks start and end just after a falling clock edge
    task automatic do_write(logic [5:0] c);
        wr_valid = 1'b1;
        wr_code  = c;
        @(negedge clk);
        wr_valid = 1'b0;
        if (mdl_ptr < N) begin
            mdl_buf[mdl_ptr] = c;
            mdl_ptr++;
        end
    endtask

    task automatic raise_strobe();
        line_strobe = 1'b1;
        @(negedge clk);
        mdl_ptr = 0;
    endtask

    task automatic lower_strobe(logic p);
        line_strobe = 1'b0;
        pol_sel     = p;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            mdl_out[i] = mdl_buf[i];
            mdl_up[i]  = ((i % 2) == 0) ? p : ~p;
        end
    endtask

    task automatic strobe(logic p);
        raise_strobe();
        @(negedge clk);
        lower_strobe(p);
    endtask

    task automatic t_reset();
        check_all("R1 code", "R1 upper");
    endtask

    task automatic t_basic();
        logic [5:0] v [N] = '{6'h00, 6'h0F, 6'h10, 6'h1F, 6'h20, 6'h2F, 6'h30, 6'h3F};
        for (int i = 0; i < N; i++) do_write(v[i]);
        check_all("R5 hold before strobe", "R5 upper hold");
        strobe(1'b1);
        check_all("R2 R4 transfer", "R7 pol high");
    endtask

    task automatic t_pol_low();
        strobe(1'b0);
        check_all("R4 retransfer", "R7 pol low");
    endtask

    task automatic t_overflow();
        logic [5:0] v [N] = '{6'h11, 6'h22, 6'h33, 6'h04, 6'h15, 6'h26, 6'h37, 6'h08};
        for (int i = 0; i < N; i++) do_write(v[i]);
        do_write(6'h3E);
        do_write(6'h3D);
        strobe(1'b1);
        check_all("R6 extra writes ignored", "R7 pol high");
    endtask

    task automatic t_mid_strobe();
        for (int i = 0; i < N; i++) do_write(6'(i + 1));
        raise_strobe();
        do_write(6'h2A);
        do_write(6'h15);
        check_all("R5 writes while high", "R5 upper while high");
        lower_strobe(1'b0);
        check_all("R3 pointer rewound", "R7 pol low");
    endtask

    task automatic t_pol_hold();
        pol_sel = 1'b1;
        repeat (4) @(negedge clk);
        do_write(6'h3C);
        check_all("R8 code hold", "R8 pol held");
        pol_sel = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mdl_buf[i] = '0;
            mdl_out[i] = '0;
            mdl_up[i]  = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_pol_low();
        t_overflow();
        t_mid_strobe();
        t_pol_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule